// File: doc/BRIEF.md
# Bus-Mapped Iterative Unsigned Divider

This peripheral divides an unsigned 16-bit dividend by an unsigned 8-bit divisor and gives a 16-bit quotient and a 16-bit remainder. A processor loads the operands through a byte-wide register bus. The write of the divisor byte is the only thing that launches an operation. The divider then produces one quotient bit for each pulse of a CPU-cycle enable, so the operation always takes the same number of processor cycles, whatever the clock rate. The result registers can be read at any moment. A read while the sequence is running returns the partial state and never stalls the bus.

The remainder register is shared with the product of a companion unsigned multiplier, so the block holds either one division result or one multiplication result. The multiplier's arithmetic is not part of this block. Its only effect modelled here is what a write of its second operand does to the quotient register. A zero divisor needs no special path: the shift-subtract loop itself leaves an all-ones quotient and a remainder equal to the dividend.

Top module: `div_top`

## Requirements
- R1: After a synchronous active-low reset, the quotient (read addresses 4 low, 5 high) and the remainder (read addresses 6 low, 7 high) all read 0.
- R2: A write to address 2 (the divisor byte) starts a division. Right after that write the quotient register holds the dividend and the remainder reads 0. Writes to address 0 (dividend low byte) or address 1 (dividend high byte) start nothing and leave both result registers unchanged.
- R3: After 16 cycles with `cpu_en` high following the start, the quotient equals dividend / divisor and the remainder equals dividend mod divisor, both unsigned.
- R4: The sequence advances only on clock edges where `cpu_en` is 1. With `cpu_en` low, the result registers hold their values.
- R5: Each enabled cycle shifts one new quotient bit into bit 0 of the quotient register, most significant result bit first. A mid-sequence read returns this partial value, not the final one.
- R6: A divisor of 0 gives a quotient of 0xFFFF and a remainder equal to the dividend.
- R7: Writing the divisor while a division is running restarts the sequence from the current dividend and divisor registers. The result is correct 16 enabled cycles after the restart.
- R8: A write to address 3 (multiplier second operand) loads that byte into the quotient low byte, clears the quotient high byte, leaves the remainder unchanged and ends any running division.
- R9: Reads of addresses 0 to 3 return 0.
- R10: Once the sequence has finished, further enabled cycles leave the quotient and remainder unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_en | input | 1 | One pulse per processor cycle; advances the division |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |

## Verification
The bench runs operand pairs that exercise the extremes: the largest dividend over the largest divisor, a dividend smaller than the divisor, and a power-of-two dividend. An off-by-one step count or a wrong comparison width in the trial subtraction would give a wrong quotient bit on one of these. It holds `cpu_en` low after a start to catch a design that counts clock edges instead of enables. It reads partway through a run to catch results that are frozen or copied in late. The zero divisor, a restart in mid-run, and a multiplier-operand write, both in mid-run and after completion, are each checked. These catch a design that special-cases zero wrongly, keeps the old operands on a restart, or lets a cancelled run keep overwriting the quotient.

// File: rtl/div_pkg.sv
// Package: register address map and shared constants for the divider.
// Assumes byte-wide bus data and a 16-bit dividend (two byte lanes).
package div_pkg;
    localparam int BUS_W     = 8;
    localparam int DVD_BASE  = 0;  // dividend low/high lanes
    localparam int DVS_ADDR  = 2;  // divisor byte, starts a division
    localparam int MULB_ADDR = 3;  // multiplier second operand
    localparam int QUO_BASE  = 4;  // quotient low/high lanes
    localparam int REM_BASE  = 6;  // remainder low/high lanes

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_START = 2'd1,
        ACT_MULB  = 2'd2
    } div_act_e;
endpackage

// File: rtl/div_regs.sv
// Operand registers: holds the dividend lanes and the divisor, and decodes
// the two writes that act on the sequencer (divisor start, multiplier operand).
// Assumes NUM_W is a multiple of the bus width and DEN_W <= bus width.
module div_regs
    import div_pkg::*;
#(
    parameter int NUM_W  = 16,
    parameter int DEN_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [NUM_W-1:0]  dividend,
    output logic [DEN_W-1:0]  divisor,
    output div_act_e          act,
    output logic [BUS_W-1:0]  act_byte
);
    localparam int LANES = NUM_W / BUS_W;

    logic [BUS_W-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture one dividend byte lane on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(DVD_BASE + g))
                lane_q[g] <= bus_wdata;
        end
        assign dividend[g*BUS_W +: BUS_W] = lane_q[g];
    end

    // Capture the divisor byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            divisor <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(DVS_ADDR))
            divisor <= bus_wdata[DEN_W-1:0];
    end

    // Decode the writes that command the sequencer.
    always_comb begin
        act      = ACT_NONE;
        act_byte = bus_wdata;
        if (bus_wr && bus_addr == ADDR_W'(DVS_ADDR))
            act = ACT_START;
        else if (bus_wr && bus_addr == ADDR_W'(MULB_ADDR))
            act = ACT_MULB;
    end
endmodule

// File: rtl/div_step.sv
// One restoring-division step: shifts the top quotient-register bit into the
// partial remainder, subtracts the divisor when it fits and shifts the new
// result bit in at bit 0. Purely combinational.
// Assumes the partial remainder stays below a nonzero divisor; with a zero
// divisor every trial fits and the remainder collects the dividend bits.
module div_step #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 8
) (
    input  logic [NUM_W-1:0] rem_in,
    input  logic [NUM_W-1:0] quo_in,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] rem_out,
    output logic [NUM_W-1:0] quo_out
);
    logic [NUM_W:0] trial;
    logic [NUM_W:0] den_x;
    logic [NUM_W:0] diff;
    logic           fits;

    // Form the trial remainder and compare it with the divisor.
    always_comb begin
        trial   = {rem_in, quo_in[NUM_W-1]};
        den_x   = (NUM_W+1)'(den);
        fits    = (trial >= den_x);
        diff    = trial - den_x;
        rem_out = fits ? diff[NUM_W-1:0] : trial[NUM_W-1:0];
        quo_out = {quo_in[NUM_W-2:0], fits};
    end
endmodule

// File: rtl/div_core.sv
// Sequencer: owns the quotient, remainder and step counter. A start loads
// the dividend and clears the remainder, a multiplier-operand write overrides
// the quotient and stops the run, and each enabled cycle runs one step.
// Assumes the divisor register is stable while a run is in progress.
module div_core
    import div_pkg::*;
#(
    parameter int NUM_W = 16,
    parameter int DEN_W = 8,
    parameter int STEPS = NUM_W,
    parameter int CNT_W = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_en,
    input  div_act_e         act,
    input  logic [BUS_W-1:0] act_byte,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic [NUM_W-1:0] quot,
    output logic [NUM_W-1:0] rem,
    output logic [CNT_W-1:0] cnt
);
    logic [NUM_W-1:0] rem_nx;
    logic [NUM_W-1:0] quo_nx;

    div_step #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_step (
        .rem_in (rem),
        .quo_in (quot),
        .den    (divisor),
        .rem_out(rem_nx),
        .quo_out(quo_nx)
    );

    // Load, override or advance the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot <= '0;
            rem  <= '0;
            cnt  <= '0;
        end else if (act == ACT_START) begin
            quot <= dividend;
            rem  <= '0;
            cnt  <= CNT_W'(STEPS);
        end else if (act == ACT_MULB) begin
            quot <= NUM_W'(act_byte);
            cnt  <= '0;
        end else if (cpu_en && cnt != '0) begin
            quot <= quo_nx;
            rem  <= rem_nx;
            cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/div_rdmux.sv
// Read path: selects a quotient or remainder byte lane by address and
// returns 0 for every other address. Combinational, so reads never stall.
module div_rdmux
    import div_pkg::*;
#(
    parameter int NUM_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_W-1:0]  quot,
    input  logic [NUM_W-1:0]  rem,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int LANES = NUM_W / BUS_W;

    // Pick the addressed lane of either result register.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            if (bus_addr == ADDR_W'(QUO_BASE + i))
                bus_rdata = quot[i*BUS_W +: BUS_W];
            if (bus_addr == ADDR_W'(REM_BASE + i))
                bus_rdata = rem[i*BUS_W +: BUS_W];
        end
    end
endmodule

// File: rtl/div_top.sv
// Top of the bus-mapped divider: operand registers, sequencer and read path.
// Assumes cpu_en pulses once per processor cycle in the clk domain.
module div_top
    import div_pkg::*;
#(
    parameter int NUM_W  = 16,
    parameter int DEN_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int STEPS = NUM_W;
    localparam int CNT_W = $clog2(STEPS + 1);

    logic [NUM_W-1:0] dividend;
    logic [DEN_W-1:0] divisor;
    div_act_e         act;
    logic [BUS_W-1:0] act_byte;
    logic [NUM_W-1:0] quot;
    logic [NUM_W-1:0] rem;
    logic [CNT_W-1:0] cnt;

    div_regs #(.NUM_W(NUM_W), .DEN_W(DEN_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .dividend (dividend),
        .divisor  (divisor),
        .act      (act),
        .act_byte (act_byte)
    );

    div_core #(.NUM_W(NUM_W), .DEN_W(DEN_W), .STEPS(STEPS), .CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_en  (cpu_en),
        .act     (act),
        .act_byte(act_byte),
        .dividend(dividend),
        .divisor (divisor),
        .quot    (quot),
        .rem     (rem),
        .cnt     (cnt)
    );

    div_rdmux #(.NUM_W(NUM_W), .ADDR_W(ADDR_W)) u_rd (
        .bus_addr (bus_addr),
        .quot     (quot),
        .rem      (rem),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/div_chk.sv
// Checker: temporal properties of the divider, bound into div_top.
module div_chk
    import div_pkg::*;
#(
    parameter int NUM_W  = 16,
    parameter int DEN_W  = 8,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [NUM_W-1:0]  quot,
    input logic [NUM_W-1:0]  rem,
    input logic [DEN_W-1:0]  divisor,
    input logic [CNT_W-1:0]  cnt
);
    localparam int STEPS = NUM_W;

    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == ADDR_W'(DVS_ADDR) || bus_addr == ADDR_W'(MULB_ADDR));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(DVS_ADDR) |=> cnt == CNT_W'(STEPS) && rem == '0);

    // R8
    mulb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(MULB_ADDR)
        |=> quot == NUM_W'($past(bus_wdata)) && $stable(rem) && cnt == '0);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_en && !cmd_wr |=> $stable(quot) && $stable(rem));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == '0 && !cmd_wr |=> $stable(quot) && $stable(rem) && cnt == '0);

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == CNT_W'(1) && cpu_en && !cmd_wr && divisor == '0 |=> quot == '1);

    // R5
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en && cnt != '0 && !cmd_wr |=> cnt == $past(cnt) - 1'b1);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(STEPS));
endmodule

bind div_top div_chk #(
    .NUM_W (NUM_W),
    .DEN_W (DEN_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_en   (cpu_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .quot     (quot),
    .rem      (rem),
    .divisor  (divisor),
    .cnt      (cnt)
);

// File: tb/tb_div_top.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks push expected read bytes, the monitor pops
// and compares them against bus_rdata on the falling edge.
module tb_div_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    div_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    // Monitor: compare one expected byte per falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s addr %0d actual %h expected %h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic run_en(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cpu_en = 1'b1;
        end
        @(posedge clk); #1;
        cpu_en = 1'b0;
    endtask

    task automatic exp_byte(input logic [2:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic exp16(input logic [2:0] base, input logic [15:0] v, input string t);
        exp_byte(base, v[7:0], t);
        exp_byte(base + 3'd1, v[15:8], t);
    endtask

    task automatic start_div(input logic [15:0] a, input logic [7:0] b);
        wr_reg(3'd0, a[7:0]);
        wr_reg(3'd1, a[15:8]);
        wr_reg(3'd2, b);
    endtask

    task automatic div_case(input logic [15:0] a, input logic [7:0] b, input string t);
        logic [15:0] q, r;
        q = (b == 0) ? 16'hFFFF : a / {8'd0, b};
        r = (b == 0) ? a : a % {8'd0, b};
        start_div(a, b);
        run_en(16);
        exp16(3'd4, q, t);
        exp16(3'd6, r, t);
    endtask

    task automatic direct16(input logic [2:0] base, output logic [15:0] v);
        @(posedge clk); #1; bus_addr = base;        #1; v[7:0]  = bus_rdata;
        @(posedge clk); #1; bus_addr = base + 3'd1; #1; v[15:8] = bus_rdata;
    endtask

    initial begin
        logic [15:0] mid;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        exp16(3'd4, 16'h0000, "R1 quotient");
        exp16(3'd6, 16'h0000, "R1 remainder");

        // R2: dividend writes start nothing
        wr_reg(3'd0, 8'h34);
        wr_reg(3'd1, 8'h12);
        run_en(20);
        exp16(3'd4, 16'h0000, "R2 no start");
        // R9: write-only addresses read 0
        exp_byte(3'd0, 8'h00, "R9 addr0");
        exp_byte(3'd2, 8'h00, "R9 addr2");

        // R3: several operand pairs
        div_case(16'hFFFF, 8'hFF, "R3 max/max");
        div_case(16'd1000, 8'd7, "R3 1000/7");
        div_case(16'h8000, 8'd3, "R3 pow2/3");
        div_case(16'd5, 8'd200, "R3 small/large");

        // R2 / R4: loaded state holds while cpu_en is low
        start_div(16'hABCD, 8'h13);
        repeat (10) @(posedge clk);
        exp16(3'd4, 16'hABCD, "R4 hold quotient");
        exp16(3'd6, 16'h0000, "R4 hold remainder");
        // R5: mid-sequence read is partial
        run_en(8);
        direct16(3'd4, mid);
        checks++;
        if (mid == 16'(16'hABCD / 16'h13)) begin
            errors++;
            $display("FAIL R5 mid read actual %h expected not %h", mid, 16'(16'hABCD / 16'h13));
        end
        run_en(8);
        exp16(3'd4, 16'hABCD / 16'h13, "R5 final quotient");
        exp16(3'd6, 16'hABCD % 16'h13, "R5 final remainder");
        // R10: extra enables change nothing
        run_en(5);
        exp16(3'd4, 16'hABCD / 16'h13, "R10 quotient");
        exp16(3'd6, 16'hABCD % 16'h13, "R10 remainder");

        // R6: zero divisor
        div_case(16'h4321, 8'h00, "R6 zero divisor");

        // R7: restart mid-run
        start_div(16'd1000, 8'd7);
        run_en(5);
        start_div(16'd50000, 8'd9);
        run_en(16);
        exp16(3'd4, 16'd5555, "R7 restart quotient");
        exp16(3'd6, 16'd5, "R7 restart remainder");

        // R8: operand-B write after completion keeps the remainder
        wr_reg(3'd3, 8'h5A);
        exp16(3'd4, 16'h005A, "R8 quotient");
        exp16(3'd6, 16'd5, "R8 remainder kept");
        // R8: operand-B write cancels a running division
        start_div(16'h7777, 8'h05);
        run_en(4);
        wr_reg(3'd3, 8'hC3);
        run_en(16);
        exp16(3'd4, 16'h00C3, "R8 cancel");

        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule